// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the 8-bit status word of a small microcontroller core. After each ALU operation it captures four arithmetic flags: carry, auxiliary (half) carry, zero and signed overflow. It derives them from the operands, the result and the full-width carry-out that the datapath supplies. Which flags change depends on the operation class on the same cycle. Addition and subtraction update all four. Logical operations update only zero. Rotate-through-carry updates only carry. An idle class changes nothing.

The same word also holds two system flags: one that records entry into power-down and one that records a watchdog expiry. Single-cycle strobes from the core and the watchdog set and clear them: power-up, watchdog clear, halt and watchdog time-out. Software can write the four arithmetic flags through a write port. It cannot write the two system flags.

Top module: `alu_flag_reg`

## Requirements
- R1: While `rst_n` is low, `status` reads 0x00 on the following clock edge.
- R2: The status word layout is C at bit 0, AC at bit 1, Z at bit 2, OV at bit 3, PDF at bit 4 and TO at bit 5, and bits 7 and 6 always read 0.
- R3: Carry takes `alu_cout` for add (`op_cls`=1), subtract (`op_cls`=2) and rotate-through-carry (`op_cls`=4). For subtract, `alu_cout`=1 means no borrow, so C=1 when the operation did not borrow.
- R4: Auxiliary carry is set for add when the low nibble (bits 3..0) carries into bit 4, and for subtract when the low nibble does not borrow from bit 4. Otherwise it is cleared.
- R5: Zero is set when `alu_res` equals 0 for add, subtract and logic (`op_cls`=3), and is cleared otherwise.
- R6: Overflow is set for add and subtract when the carry into the top result bit differs from `alu_cout`, and is cleared otherwise.
- R7: Logic keeps C, AC and OV. Rotate-through-carry keeps AC, Z and OV. Idle (`op_cls`=0) keeps every flag.
- R8: PDF is set by `halt`, and cleared by `pwr_up` or `wdt_clr` when `halt` is low. When a set and a clear meet in one cycle, the set wins.
- R9: TO is set by `wdt_tmo`, and cleared by `pwr_up`, `wdt_clr` or `halt` when `wdt_tmo` is low. When a set and a clear meet in one cycle, the set wins.
- R10: A software write (`sw_we`) loads bits 3..0 from `sw_wdata` and leaves PDF and TO unchanged. In the same cycle, any flag that the ALU operation updates takes the ALU value instead of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_cls | input | 3 | Operation class: 0 idle, 1 add, 2 subtract, 3 logic, 4 rotate through carry |
| opnd_a | input | DATA_W | First ALU operand |
| opnd_b | input | DATA_W | Second ALU operand (subtrahend for subtract) |
| alu_res | input | DATA_W | ALU result |
| alu_cout | input | 1 | Full-width carry-out; inverted borrow for subtract; shifted-out bit for rotate |
| pwr_up | input | 1 | Power-up event strobe |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 8 | Software write data |
| status | output | 8 | Registered status word |

## Verification
Two kinds of same-cycle collision need checking. The first is between the set and clear strobes of a system flag: time-out with watchdog clear or power-up, and halt with watchdog clear. The bench drives each pair on one cycle and expects the set to win. The second is between a software write and an ALU update. The bench issues a write of all ones together with an add and then together with a logic operation. It expects the ALU value in every field that the operation class owns, and the written value only in the fields that the operation leaves alone.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OPC_IDLE  = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_LOGIC = 3'd3,
        OPC_ROTC  = 3'd4
    } op_cls_e;

    // Bit positions inside the status word (software visible).
    localparam int unsigned POS_C   = 0;
    localparam int unsigned POS_AC  = 1;
    localparam int unsigned POS_Z   = 2;
    localparam int unsigned POS_OV  = 3;
    localparam int unsigned POS_PDF = 4;
    localparam int unsigned POS_TO  = 5;
    localparam int unsigned STAT_W  = 8;

    typedef struct packed {
        logic to;
        logic pdf;
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flags_t;

    typedef struct packed {
        logic upd_c;
        logic upd_ac;
        logic upd_z;
        logic upd_ov;
        logic c;
        logic ac;
        logic z;
        logic ov;
    } arith_upd_t;

endpackage

// File: rtl/alu_flag_arith.sv
module alu_flag_arith
    import alu_flag_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned HALF_AT = 4
) (
    input  logic [2:0]        op_cls,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    output arith_upd_t        upd
);
    localparam int unsigned TOP = DATA_W - 1;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin_bit;

    assign is_sub = (op_cls == OPC_SUB);

    // Subtract is modelled as a + ~b + 1, so carries are inverted borrows.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_carry_in
            assign b_eff[i]   = opnd_b[i] ^ is_sub;
            assign cin_bit[i] = opnd_a[i] ^ b_eff[i] ^ alu_res[i];
        end
    endgenerate

    always_comb begin
        upd = '0;
        unique case (op_cls)
            OPC_ADD, OPC_SUB: begin
                upd.upd_c  = 1'b1;
                upd.upd_ac = 1'b1;
                upd.upd_z  = 1'b1;
                upd.upd_ov = 1'b1;
            end
            OPC_LOGIC: upd.upd_z = 1'b1;
            OPC_ROTC:  upd.upd_c = 1'b1;
            default: ;
        endcase
        upd.c  = alu_cout;
        upd.ac = cin_bit[HALF_AT];
        upd.z  = (alu_res == '0);
        upd.ov = cin_bit[TOP] ^ alu_cout;
    end

endmodule

// File: rtl/alu_flag_sys.sv
module alu_flag_sys (
    input  logic pdf_q,
    input  logic to_q,
    input  logic pwr_up,
    input  logic wdt_clr,
    input  logic halt,
    input  logic wdt_tmo,
    output logic pdf_d,
    output logic to_d
);
    logic pdf_clr;
    logic to_clr;

    assign pdf_clr = pwr_up | wdt_clr;
    assign to_clr  = pwr_up | wdt_clr | halt;

    // A set event always dominates a clear event in the same cycle.
    always_comb begin
        pdf_d = pdf_q;
        if (halt)         pdf_d = 1'b1;
        else if (pdf_clr) pdf_d = 1'b0;

        to_d = to_q;
        if (wdt_tmo)     to_d = 1'b1;
        else if (to_clr) to_d = 1'b0;
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned HALF_AT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_cls,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    input  logic              pwr_up,
    input  logic              wdt_clr,
    input  logic              halt,
    input  logic              wdt_tmo,
    input  logic              sw_we,
    input  logic [7:0]        sw_wdata,
    output logic [7:0]        status
);
    localparam int unsigned FLAG_W = $bits(flags_t);

    flags_t     flg_d, flg_q;
    arith_upd_t aupd;
    logic       pdf_n, to_n;

    alu_flag_arith #(.DATA_W(DATA_W), .HALF_AT(HALF_AT)) u_arith (
        .op_cls   (op_cls),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .alu_res  (alu_res),
        .alu_cout (alu_cout),
        .upd      (aupd)
    );

    alu_flag_sys u_sys (
        .pdf_q   (flg_q.pdf),
        .to_q    (flg_q.to),
        .pwr_up  (pwr_up),
        .wdt_clr (wdt_clr),
        .halt    (halt),
        .wdt_tmo (wdt_tmo),
        .pdf_d   (pdf_n),
        .to_d    (to_n)
    );

    always_comb begin
        flg_d = flg_q;
        if (sw_we) begin
            flg_d.c  = sw_wdata[POS_C];
            flg_d.ac = sw_wdata[POS_AC];
            flg_d.z  = sw_wdata[POS_Z];
            flg_d.ov = sw_wdata[POS_OV];
        end
        if (aupd.upd_c)  flg_d.c  = aupd.c;
        if (aupd.upd_ac) flg_d.ac = aupd.ac;
        if (aupd.upd_z)  flg_d.z  = aupd.z;
        if (aupd.upd_ov) flg_d.ov = aupd.ov;
        flg_d.pdf = pdf_n;
        flg_d.to  = to_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    always_comb begin
        status              = '0;
        status[POS_C]       = flg_q.c;
        status[POS_AC]      = flg_q.ac;
        status[POS_Z]       = flg_q.z;
        status[POS_OV]      = flg_q.ov;
        status[POS_PDF]     = flg_q.pdf;
        status[POS_TO]      = flg_q.to;
        status[7:FLAG_W]    = '0;
    end

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_cls,
    input logic [DATA_W-1:0] alu_res,
    input logic              alu_cout,
    input logic              pwr_up,
    input logic              wdt_clr,
    input logic              halt,
    input logic              wdt_tmo,
    input logic              sw_we,
    input logic [7:0]        status
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00); // R2

    AST_C_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd1 || op_cls == 3'd2 || op_cls == 3'd4) |=> status[0] == $past(alu_cout)); // R3

    AST_Z_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd1 || op_cls == 3'd2 || op_cls == 3'd3) |=> status[2] == ($past(alu_res) == '0)); // R5

    AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd3 && !sw_we) |=> (status[0] == $past(status[0]) && status[1] == $past(status[1]) && status[3] == $past(status[3]))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd0 && !sw_we && !pwr_up && !wdt_clr && !halt && !wdt_tmo) |=> $stable(status)); // R7

    AST_PDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> status[4]); // R8

    AST_PDF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_up || wdt_clr) && !halt) |=> !status[4]); // R8

    AST_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> status[5]); // R9

    AST_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_up || wdt_clr || halt) && !wdt_tmo) |=> !status[5]); // R9

    AST_SYS_NO_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !pwr_up && !wdt_clr && !halt && !wdt_tmo) |=> $stable(status[5:4])); // R10

endmodule

bind alu_flag_reg alu_flag_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_cls   (op_cls),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .pwr_up   (pwr_up),
    .wdt_clr  (wdt_clr),
    .halt     (halt),
    .wdt_tmo  (wdt_tmo),
    .sw_we    (sw_we),
    .status   (status)
);

// File: tb/alu_flag_reg_bench.sv
module alu_flag_reg_bench;
    localparam int unsigned DW = 8;
    localparam int NVEC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_cls = '0;
    logic [DW-1:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic          alu_cout = 1'b0;
    logic          pwr_up = 1'b0, wdt_clr = 1'b0, halt = 1'b0, wdt_tmo = 1'b0;
    logic          sw_we = 1'b0;
    logic [7:0]    sw_wdata = '0;
    logic [7:0]    status;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    alu_flag_reg #(.DATA_W(DW)) u_alu_flag_reg (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .alu_res(alu_res), .alu_cout(alu_cout),
        .pwr_up(pwr_up), .wdt_clr(wdt_clr), .halt(halt), .wdt_tmo(wdt_tmo),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .status(status)
    );

    // {op[2:0], a[7:0], b[7:0], res[7:0], cout, expected {OV,Z,AC,C}}
    localparam logic [31:0] VEC [NVEC] = '{
        {3'd1, 8'h0F, 8'h01, 8'h10, 1'b0, 4'b0010}, // R4 half carry
        {3'd1, 8'h7F, 8'h01, 8'h80, 1'b0, 4'b1010}, // R6 add overflow
        {3'd1, 8'hFF, 8'h01, 8'h00, 1'b1, 4'b0111}, // R3 R5 carry, zero
        {3'd2, 8'h05, 8'h03, 8'h02, 1'b1, 4'b0011}, // R3 no borrow
        {3'd2, 8'h03, 8'h05, 8'hFE, 1'b0, 4'b0000}, // R4 borrow
        {3'd2, 8'h80, 8'h01, 8'h7F, 1'b1, 4'b1001}, // R6 sub overflow
        {3'd2, 8'h10, 8'h10, 8'h00, 1'b1, 4'b0111}, // R5 sub zero
        {3'd3, 8'hF0, 8'h0F, 8'h55, 1'b0, 4'b0011}, // R7 logic keeps C/AC/OV
        {3'd4, 8'h55, 8'h00, 8'hAA, 1'b0, 4'b0010}, // R3 rotate
        {3'd3, 8'hAA, 8'h55, 8'h00, 1'b1, 4'b0110}, // R5 logic zero
        {3'd0, 8'hFF, 8'hFF, 8'h00, 1'b1, 4'b0110}, // R7 idle
        {3'd4, 8'h81, 8'h00, 8'h03, 1'b1, 4'b0111}  // R7 rotate keeps Z
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (status !== exp) begin
            n_err++;
            $display("FAIL %s status=%02h expected=%02h", req, status, exp);
        end
    endtask

    task automatic clear_in();
        op_cls = '0; opnd_a = '0; opnd_b = '0; alu_res = '0; alu_cout = 1'b0;
        pwr_up = 1'b0; wdt_clr = 1'b0; halt = 1'b0; wdt_tmo = 1'b0;
        sw_we = 1'b0; sw_wdata = '0;
    endtask

    // Inputs already set at a falling edge; one rising edge captures them.
    task automatic cycle();
        @(negedge clk);
        clear_in();
    endtask

    task automatic sys(input logic p, input logic w, input logic h, input logic t);
        pwr_up = p; wdt_clr = w; halt = h; wdt_tmo = t;
        cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            op_cls   = VEC[i][31:29];
            opnd_a   = VEC[i][28:21];
            opnd_b   = VEC[i][20:13];
            alu_res  = VEC[i][12:5];
            alu_cout = VEC[i][4];
            cycle();
            check($sformatf("R3-6/R7 vec%0d", i), {4'h0, VEC[i][3:0]});
        end

        sw_we = 1'b1; sw_wdata = 8'hFF; cycle();
        check("R10 R2 write bits 3..0 only", 8'h0F);
        sys(0, 0, 1, 0); check("R8 halt sets PDF", 8'h1F);
        sys(0, 0, 0, 1); check("R9 timeout sets TO", 8'h3F);
        sys(0, 1, 0, 1); check("R9 timeout beats clear", 8'h2F);
        sys(0, 0, 1, 0); check("R9 halt clears TO", 8'h1F);
        sys(0, 1, 1, 0); check("R8 halt beats clear", 8'h1F);
        sys(0, 1, 0, 0); check("R8 wdt clear clears PDF", 8'h0F);
        sys(0, 0, 0, 1); check("R9 set again", 8'h2F);
        sys(1, 0, 0, 0); check("R9 power-up clears TO", 8'h0F);
        sys(1, 0, 0, 1); check("R9 timeout beats power-up", 8'h2F);
        sys(1, 0, 1, 0); check("R8 halt beats power-up", 8'h1F);

        sw_we = 1'b1; sw_wdata = 8'hFF;
        op_cls = 3'd1; opnd_a = 8'h01; opnd_b = 8'h01; alu_res = 8'h02; alu_cout = 1'b0;
        cycle();
        check("R10 add overrides write", 8'h10);

        sw_we = 1'b1; sw_wdata = 8'hFF;
        op_cls = 3'd3; alu_res = 8'h33;
        cycle();
        check("R10 logic owns only Z", 8'h1B);

        opnd_a = 8'hFF; alu_res = 8'h00; alu_cout = 1'b0; sw_wdata = 8'h00;
        cycle();
        check("R7 idle hold, write strobe low", 8'h1B);

        rst_n = 1'b0; cycle();
        check("R1 reset clears all", 8'h00);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung, done=0 expected=1");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule